// File: doc/BRIEF.md
# Serial Bit-Rate Timing Generator

This block derives serial bit timing from the system clock for a serial port that runs either asynchronously or as a synchronous clock master. A fixed prescaler divides the clock by `PRE_DIV`, four by default. A down-counting timer divides the result again by X+1, where X is an 8-bit reload value. In asynchronous operation a second stage groups the timer ticks into bits. That stage uses 16 ticks per bit in the normal-speed setting and 4 ticks per bit in the high-speed setting. The total division is therefore 64·(X+1) or 16·(X+1) clocks per bit. In synchronous operation every timer tick is one bit, which gives 4·(X+1) clocks per bit, and the speed select has no effect.

Any write to the reload value restarts the whole chain at once, so the new rate starts without waiting for the old period to end. The receive line first passes through a synchronizer. In asynchronous operation it is then sampled on the three oversampling ticks around the middle of each bit. A majority vote of those three samples gives the bit level, which comes out with a one-cycle valid strobe. Dropping `enable` holds every counter at its reload state.

Top module: `serial_rate_gen`

## Requirements
- R1: During and just after reset, the reload value is 0, no strobe is active, `rx_bit` reads 1 and `rx_bit_valid` reads 0.
- R2: While enabled in asynchronous mode, `sample_tick` pulses for one cycle every `PRE_DIV`·(X+1) clocks. It never pulses in synchronous mode.
- R3: In asynchronous mode with `fast_sel` = 0, `bit_tick` pulses on every 16th `sample_tick`, which is every 64·(X+1) clocks.
- R4: In asynchronous mode with `fast_sel` = 1, `bit_tick` pulses on every 4th `sample_tick`, which is every 16·(X+1) clocks.
- R5: In synchronous mode (`sync_sel` = 1), `bit_tick` pulses every 4·(X+1) clocks whatever the value of `fast_sel`, and `rx_bit_valid` stays 0.
- R6: A `reload_wr` pulse stores `reload_data` and restarts the chain. The first `sample_tick` after the write comes in the cycle that ends `PRE_DIV`·(X+1) clock edges after the write edge, and the bit grouping starts again from zero.
- R7: While `enable` is 0 no strobe fires and the counters hold their reload state. After `enable` returns to 1, the first tick comes `PRE_DIV`·(X+1) cycles after the first disabled cycle's restart.
- R8: `rx_in` passes through two flip-flops that reset to 1 before it is sampled.
- R9: The samples are taken on the oversampling ticks numbered N/2−1, N/2 and N/2+1 within a bit, counting from 0, where N is the number of ticks per bit. `rx_bit` becomes the majority of the three samples.
- R10: `rx_bit_valid` pulses for one cycle in the cycle after the third sample tick. `rx_bit` holds its value until the next vote. A restart discards a vote that has not finished.
- R11: With X = 25, asynchronous mode and `fast_sel` = 0, successive `bit_tick` pulses are 1664 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; while low, counters are held at their reload state |
| reload_wr | input | 1 | Write strobe for the reload value; restarts the timing chain |
| reload_data | input | RELOAD_W | New reload value X |
| fast_sel | input | 1 | Asynchronous high-speed select (4 ticks per bit instead of 16) |
| sync_sel | input | 1 | Synchronous master mode select |
| rx_in | input | 1 | Asynchronous receive line |
| sample_tick | output | 1 | Oversampling strobe (asynchronous mode only) |
| bit_tick | output | 1 | One-cycle strobe per bit period |
| rx_bit | output | 1 | Majority-voted receive bit level |
| rx_bit_valid | output | 1 | One-cycle strobe marking a new `rx_bit` |

## Verification
The bench builds the block with its default parameters: a prescale of 4, 16 and 4 ticks per bit, and a two-stage synchronizer. It uses small reload values (0 to 3) so that many complete bits, votes and mode changes fit in a short run, and it also uses X = 25 to check the 1664-clock bit period. Because the high-speed grouping uses only four ticks, its vote window is packed against the end of the bit. This setting therefore exercises the case where the third sample and the bit boundary fall on the same tick. A randomly toggling receive line produces both unanimous votes and votes of two against one.

// File: rtl/serial_rate_pkg.sv
package serial_rate_pkg;

   // majority of three samples
   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   // position of the first vote sample inside a bit of n ticks
   function automatic int vote_first(input int n);
      return (n / 2) - 1;
   endfunction

endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
   parameter int PRE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic pre_en
);
   localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

   logic [PW-1:0] cnt;

   initial begin : param_chk
      assert (PRE_DIV >= 2) else $error("PRE_DIV must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign pre_en = run && (cnt == LAST);

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/rate_timer.sv
module rate_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] load_val,
   input  logic         pre_en,
   output logic         tick
);
   logic [W-1:0] tmr;

   initial begin : param_chk
      assert (W >= 1 && W <= 16) else $error("reload width out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmr <= '0;
      else if (restart)
         tmr <= load_val;
      else if (pre_en) begin
         if (tmr == '0)
            tmr <= load_val;
         else
            tmr <= tmr - 1'b1;
      end
   end

   assign tick = pre_en && (tmr == '0);

endmodule

// File: rtl/rate_subdiv.sv
module rate_subdiv
   import serial_rate_pkg::*;
#(
   parameter int SLOW_OVS = 16,
   parameter int FAST_OVS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick,
   input  logic fast_sel,
   input  logic sync_sel,
   output logic sample_tick,
   output logic bit_tick,
   output logic vote_pick,
   output logic vote_last
);
   localparam int SW = $clog2(SLOW_OVS);
   localparam logic [SW-1:0] SLOW_LIM = SW'(SLOW_OVS - 1);
   localparam logic [SW-1:0] FAST_LIM = SW'(FAST_OVS - 1);
   localparam logic [SW-1:0] SLOW_V0  = SW'(vote_first(SLOW_OVS));
   localparam logic [SW-1:0] FAST_V0  = SW'(vote_first(FAST_OVS));

   logic [SW-1:0] sub;
   logic [SW-1:0] lim;
   logic [SW-1:0] v0;
   logic          in_window;

   initial begin : param_chk
      assert (FAST_OVS >= 4) else $error("FAST_OVS must be at least 4");
      assert (SLOW_OVS >= FAST_OVS) else $error("SLOW_OVS below FAST_OVS");
   end

   assign lim = fast_sel ? FAST_LIM : SLOW_LIM;
   assign v0  = fast_sel ? FAST_V0  : SLOW_V0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sub <= '0;
      else if (restart || sync_sel)
         sub <= '0;
      else if (tick) begin
         if (sub >= lim)
            sub <= '0;
         else
            sub <= sub + 1'b1;
      end
   end

   assign in_window   = (sub == v0) || (sub == v0 + 1'b1) || (sub == v0 + 2'd2);
   assign sample_tick = tick && !sync_sel;
   assign bit_tick    = tick && (sync_sel || (sub >= lim));
   assign vote_pick   = sample_tick && in_window;
   assign vote_last   = sample_tick && (sub == v0 + 2'd2);

endmodule

// File: rtl/rx_vote.sv
module rx_vote
   import serial_rate_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic rx_in,
   input  logic pick,
   input  logic last,
   output logic rx_bit,
   output logic rx_valid
);
   logic [SYNC_STAGES-1:0] chain;
   logic                   rx_s;
   logic [1:0]             held;

   initial begin : param_chk
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= rx_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign rx_s = chain[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held     <= '0;
         rx_bit   <= 1'b1;
         rx_valid <= 1'b0;
      end else if (clear) begin
         held     <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (last) begin
            rx_bit   <= vote3(held[1], held[0], rx_s);
            rx_valid <= 1'b1;
         end else if (pick) begin
            held <= {held[0], rx_s};
         end
      end
   end

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
   parameter int RELOAD_W    = 8,
   parameter int PRE_DIV     = 4,
   parameter int SLOW_OVS    = 16,
   parameter int FAST_OVS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                reload_wr,
   input  logic [RELOAD_W-1:0] reload_data,
   input  logic                fast_sel,
   input  logic                sync_sel,
   input  logic                rx_in,
   output logic                sample_tick,
   output logic                bit_tick,
   output logic                rx_bit,
   output logic                rx_bit_valid
);
   logic [RELOAD_W-1:0] reload_q;
   logic [RELOAD_W-1:0] load_val;
   logic                restart;
   logic                pre_en;
   logic                tmr_tick;
   logic                vote_pick;
   logic                vote_last;

   always_ff @(posedge clk) begin
      if (!rst_n)
         reload_q <= '0;
      else if (reload_wr)
         reload_q <= reload_data;
   end

   assign restart  = reload_wr || !enable;
   assign load_val = reload_wr ? reload_data : reload_q;

   rate_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(enable), .restart(restart), .pre_en(pre_en)
   );

   rate_timer #(.W(RELOAD_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(restart), .load_val(load_val),
      .pre_en(pre_en), .tick(tmr_tick)
   );

   rate_subdiv #(.SLOW_OVS(SLOW_OVS), .FAST_OVS(FAST_OVS)) u_sub (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tmr_tick),
      .fast_sel(fast_sel), .sync_sel(sync_sel), .sample_tick(sample_tick),
      .bit_tick(bit_tick), .vote_pick(vote_pick), .vote_last(vote_last)
   );

   rx_vote #(.SYNC_STAGES(SYNC_STAGES)) u_vote (
      .clk(clk), .rst_n(rst_n), .clear(restart), .rx_in(rx_in),
      .pick(vote_pick), .last(vote_last), .rx_bit(rx_bit), .rx_valid(rx_bit_valid)
   );

   // R3
   bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> (sample_tick || sync_sel));

   // R10
   valid_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bit_valid |-> $past(sample_tick));

   // R5
   no_vote_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel && $past(sync_sel)) |-> !rx_bit_valid);

   // R6
   quiet_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reload_wr) |-> !tmr_tick);

endmodule

// File: tb/serial_rate_gen_test.sv
`timescale 1ns/1ps
module serial_rate_gen_test;
   localparam int PRE  = 4;
   localparam int SLOW = 16;
   localparam int FAST = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       reload_wr = 1'b0;
   logic [7:0] reload_data = 8'd0;
   logic       fast_sel = 1'b0;
   logic       sync_sel = 1'b0;
   logic       rx_in = 1'b1;
   logic       sample_tick, bit_tick, rx_bit, rx_bit_valid;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;
   bit rx_rand = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   serial_rate_gen uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .reload_wr(reload_wr),
      .reload_data(reload_data), .fast_sel(fast_sel), .sync_sel(sync_sel),
      .rx_in(rx_in), .sample_tick(sample_tick), .bit_tick(bit_tick),
      .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: cycle index since last restart, vote list
   int m_x = 0, m_c = 0, m_h1 = 1, m_h2 = 1;
   logic m_bit = 1'b1, m_valid = 1'b0;
   int m_samp[$];

   always @(posedge clk) begin : model
      int p, n, t, pos, ones;
      bit tk;
      if (!rst_n) begin
         m_x = 0; m_c = 0; m_bit = 1'b1; m_valid = 1'b0;
         m_h1 = 1; m_h2 = 1; m_samp.delete();
      end else begin
         p  = PRE * (m_x + 1);
         n  = fast_sel ? FAST : SLOW;
         tk = enable && ((m_c + 1) % p == 0);
         t  = (m_c + 1) / p;
         pos = (t > 0) ? (t - 1) % n : 0;
         m_valid = 1'b0;
         if (enable && !reload_wr && tk && !sync_sel &&
             pos >= n/2 - 1 && pos <= n/2 + 1) begin
            m_samp.push_back(m_h2);
            if (pos == n/2 + 1) begin
               ones = 0;
               foreach (m_samp[i]) ones += m_samp[i];
               m_bit = (ones >= 2);
               m_valid = 1'b1;
               m_samp.delete();
            end
         end
         if (reload_wr || !enable) begin
            m_c = 0; m_samp.delete();
         end else begin
            m_c++;
         end
         if (reload_wr) m_x = reload_data;
         m_h2 = m_h1;
         m_h1 = rx_in;
      end
   end

   always @(negedge clk) begin : compare
      int p, n, t, pos;
      bit tk, e_s, e_b;
      p  = PRE * (m_x + 1);
      n  = fast_sel ? FAST : SLOW;
      tk = rst_n && enable && ((m_c + 1) % p == 0);
      t  = (m_c + 1) / p;
      pos = (t > 0) ? (t - 1) % n : 0;
      e_s = tk && !sync_sel;
      e_b = tk && (sync_sel || pos == n - 1);
      if (!finished) begin
         chk("R2 sample_tick", sample_tick, e_s);
         chk(sync_sel ? "R5 bit_tick" : (fast_sel ? "R4 bit_tick" : "R3 bit_tick"), bit_tick, e_b);
         chk("R10 rx_bit_valid", rx_bit_valid, m_valid);
         chk("R8 R9 rx_bit", rx_bit, m_bit);
      end
   end

   // random receive line
   always @(negedge clk) begin
      #1;
      if (rx_rand) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[2:0] == 3'b000 || lfsr[2:0] == 3'b101) rx_in = ~rx_in;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic write_x(input int x);
      reload_data = 8'(x);
      reload_wr = 1'b1;
      @(posedge clk);
      #1 reload_wr = 1'b0;
   endtask

   task automatic set_mode(input bit f, input bit s, input int x);
      wait_cyc(1);
      enable = 1'b0;
      wait_cyc(1);
      fast_sel = f; sync_sel = s;
      write_x(x);
      wait_cyc(2);
      enable = 1'b1;
   endtask

   task automatic count_to_tick(input string tag, input int exp);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample_tick && n < 5000);
      chk_int(tag, n, exp);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         mismatched++; compared++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stim
      int n;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 sample_tick", sample_tick, 1'b0);
      chk("R1 bit_tick", bit_tick, 1'b0);
      chk("R1 rx_bit", rx_bit, 1'b1);
      chk("R1 rx_bit_valid", rx_bit_valid, 1'b0);
      #1 rst_n = 1'b1;
      wait_cyc(3);
      // R1: reload is 0 after reset -> first tick PRE cycles after enable
      enable = 1'b1;
      count_to_tick("R1 reload zero period", PRE - 1);
      rx_rand = 1'b1;
      wait_cyc(200);

      // R3 async slow, R9/R10 votes
      set_mode(1'b0, 1'b0, 1);
      wait_cyc(600);
      // R4 async fast
      set_mode(1'b1, 1'b0, 0);
      wait_cyc(300);
      set_mode(1'b1, 1'b0, 3);
      wait_cyc(400);
      // R5 sync, fast_sel both ways
      set_mode(1'b0, 1'b1, 2);
      wait_cyc(120);
      set_mode(1'b1, 1'b1, 2);
      wait_cyc(120);

      // R6 write while running
      set_mode(1'b0, 1'b0, 2);
      wait_cyc(150);
      write_x(2);
      count_to_tick("R6 first tick after write", PRE * 3);
      wait_cyc(300);

      // R7 disable holds, re-enable restarts
      enable = 1'b0;
      n = 0;
      repeat (30) begin
         @(negedge clk);
         if (sample_tick || bit_tick) n++;
      end
      chk_int("R7 ticks while disabled", n, 0);
      #1 enable = 1'b1;
      count_to_tick("R7 first tick after enable", PRE * 3 - 1);
      wait_cyc(100);

      // R11: X = 25 slow
      set_mode(1'b0, 1'b0, 25);
      n = 0;
      do begin @(negedge clk); n++; end while (!bit_tick && n < 5000);
      n = 0;
      do begin @(negedge clk); n++; end while (!bit_tick && n < 5000);
      chk_int("R11 bit period", n, 1664);
      wait_cyc(20);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule